// File: doc/BRIEF.md
# Selectable Binary Clock Divider with Optional Divide-by-Three

This block divides an incoming clock by a power of two picked from a chain of seven cascaded halving stages. A select code picks the chain tap that reaches the single divided output. Code 0 passes the input clock through unchanged. Code k selects the k-th halving stage, which gives a ratio of 2^k.

A separate enable places a divide-by-three stage after the selected tap. That stage keeps the duty cycle at 50%, so ratios of 3·2^k become available. When the tap is a halving stage, the divide-by-three counts both transitions of that tap. When the tap is the raw input clock, it combines a rising-edge mod-3 counter with a falling-edge copy. Either way the high and low times of the output are equal.

All halving stages are bits of one counter clocked by the input clock, so every tap changes on the same input edge. An active-low asynchronous reset clears the counter and the divide-by-three state. The block is meant to be reset after the select code or the enable changes.

Top module: `tapdiv`

## Requirements
- R1: While `rst_n` is low, the counter and the divide-by-three state are cleared. With a nonzero `sel` or with `div3_en` high, `clk_out` is 0.
- R2: With `sel` = 0 and `div3_en` = 0, `clk_out` follows `clk_in` in both clock phases.
- R3: With `sel` = k (1..7) and `div3_en` = 0, `clk_out` equals bit k-1 of the number of rising `clk_in` edges since reset released, modulo 2^7. The output period is 2^k input periods at 50% duty.
- R4: All halving stages change on the same rising input edge. Stage i (0-based) toggles exactly on the edges where all lower stages held 1.
- R5: With `sel` = k (1..7) and `div3_en` = 1, `clk_out` toggles on every third transition of tap k. It first rises after 3·2^(k-1) rising input edges. The period is 3·2^k input periods, with equal high and low times.
- R6: With `sel` = 0 and `div3_en` = 1, `clk_out` rises on the 3rd rising input edge after reset and falls on the falling edge that follows the 4th. The pattern repeats every 3 input periods, so the output is high for 1.5 periods and low for 1.5 periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 3 | Tap code: 0 passes the input clock, k selects halving stage k |
| div3_en | input | 1 | Places the 50%-duty divide-by-three after the selected tap |
| clk_out | output | 1 | Divided clock |

## Verification
A wrong counter bit shows up on the first tap that reads it within 2^k input edges. It also shows up later as a shifted or irregular period of every higher tap. A mod-3 state that skips or repeats a value moves the first rising edge of the divided output away from 3·2^(k-1) edges, and that error is visible within one output period. A missing or stale falling-edge copy in the raw divide-by-three shortens the high time to one input period, which is caught at the first falling-edge sample after the third rising edge. The bench therefore compares every half period of every select and enable combination against an arithmetic model for several full output periods.

// File: rtl/tapdiv_pkg.sv
package tapdiv_pkg;

  // Width of a code able to name taps 0..stages
  function automatic int code_width(input int stages);
    return $clog2(stages + 1);
  endfunction

  // Next state of a modulo-3 counter
  function automatic logic [1:0] mod3_next(input logic [1:0] cur);
    return (cur == 2'd2) ? 2'd0 : cur + 2'd1;
  endfunction

  // Last state of the modulo-3 cycle
  function automatic logic mod3_last(input logic [1:0] cur);
    return cur == 2'd2;
  endfunction

endpackage

// File: rtl/tapdiv_chain.sv
module tapdiv_chain #(
  parameter int STAGES = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [STAGES-1:0] cnt,
  output logic [STAGES-1:0] tick
);

  // tick[i]: stage i changes on the coming rising edge
  assign tick[0] = 1'b1;
  for (genvar i = 1; i < STAGES; i++) begin : g_tick
    assign tick[i] = &cnt[i-1:0];
  end

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt[i] <= 1'b0;
      else if (tick[i]) cnt[i] <= ~cnt[i];
    end
  end

endmodule

// File: rtl/tapdiv_tapmux.sv
module tapdiv_tapmux #(
  parameter int STAGES = 7,
  parameter int SEL_W  = 3
) (
  input  logic              clk_raw,
  input  logic [STAGES-1:0] cnt,
  input  logic [STAGES-1:0] tick,
  input  logic [SEL_W-1:0]  sel,
  output logic              tap,
  output logic              tap_tick
);

  localparam int NTAPS = 1 << SEL_W;

  logic [NTAPS-1:0] tap_vec;
  logic [NTAPS-1:0] tick_vec;

  assign tap_vec[0]  = clk_raw;
  assign tick_vec[0] = 1'b0;

  for (genvar k = 1; k < NTAPS; k++) begin : g_tap
    if (k <= STAGES) begin : g_real
      assign tap_vec[k]  = cnt[k-1];
      assign tick_vec[k] = tick[k-1];
    end else begin : g_unused
      assign tap_vec[k]  = 1'b0;
      assign tick_vec[k] = 1'b0;
    end
  end

  assign tap      = tap_vec[sel];
  assign tap_tick = tick_vec[sel];

endmodule

// File: rtl/tapdiv_third.sv
module tapdiv_third
  import tapdiv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tap_tick,
  input  logic raw_mode,
  output logic pulse,
  output logic slow,
  output logic q
);

  logic [1:0] raw_cnt;
  logic       pulse_neg;
  logic [1:0] edge_cnt;

  // Raw-clock path: one-cycle pulse every third edge, stretched by half a cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_cnt <= 2'd0;
      pulse   <= 1'b0;
    end else begin
      raw_cnt <= mod3_next(raw_cnt);
      pulse   <= mod3_last(raw_cnt);
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) pulse_neg <= 1'b0;
    else        pulse_neg <= pulse;
  end

  // Tap path: toggle on every third tap transition
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_cnt <= 2'd0;
      slow     <= 1'b0;
    end else if (tap_tick) begin
      edge_cnt <= mod3_next(edge_cnt);
      if (mod3_last(edge_cnt)) slow <= ~slow;
    end
  end

  assign q = raw_mode ? (pulse | pulse_neg) : slow;

endmodule

// File: rtl/tapdiv.sv
module tapdiv
  import tapdiv_pkg::*;
#(
  parameter int STAGES = 7,
  localparam int SEL_W = code_width(STAGES)
) (
  input  logic             clk_in,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic             div3_en,
  output logic             clk_out
);

  logic [STAGES-1:0] chain_cnt;
  logic [STAGES-1:0] chain_tick;
  logic              tap;
  logic              tick_sel;
  logic              d3_pulse;
  logic              d3_slow;
  logic              d3_out;
  logic              raw_mode;

  assign raw_mode = (sel == '0);

  tapdiv_chain #(.STAGES(STAGES)) u_chain (
    .clk   (clk_in),
    .rst_n (rst_n),
    .cnt   (chain_cnt),
    .tick  (chain_tick)
  );

  tapdiv_tapmux #(.STAGES(STAGES), .SEL_W(SEL_W)) u_mux (
    .clk_raw  (clk_in),
    .cnt      (chain_cnt),
    .tick     (chain_tick),
    .sel      (sel),
    .tap      (tap),
    .tap_tick (tick_sel)
  );

  tapdiv_third u_third (
    .clk      (clk_in),
    .rst_n    (rst_n),
    .tap_tick (tick_sel),
    .raw_mode (raw_mode),
    .pulse    (d3_pulse),
    .slow     (d3_slow),
    .q        (d3_out)
  );

  assign clk_out = div3_en ? d3_out : tap;

endmodule

// File: rtl/tapdiv_chk.sv
module tapdiv_chk #(
  parameter int STAGES = 7,
  parameter int SEL_W  = 3
) (
  input logic              clk_in,
  input logic              rst_n,
  input logic [SEL_W-1:0]  sel,
  input logic              div3_en,
  input logic              clk_out,
  input logic [STAGES-1:0] cnt,
  input logic [STAGES-1:0] tick,
  input logic              tick_sel,
  input logic              pulse,
  input logic              slow
);

  // R1: output held low in reset unless the raw clock is passed through
  always @(negedge clk_in) begin
    if (!rst_n && (sel != '0 || div3_en))
      p_reset_low_r1: assert (clk_out == 1'b0);
  end

  // R3: first tap alternates between successive rising edges
  p_tap1_toggle_r3: assert property (@(posedge clk_in) disable iff (!rst_n)
    (sel == 1 && !div3_en && $past(sel) == 1 && !$past(div3_en) && $past(rst_n))
    |-> clk_out != $past(clk_out));

  // R4: top stage changes only when every lower stage is one
  p_stage_step_r4: assert property (@(posedge clk_in) disable iff (!rst_n)
    tick[STAGES-1] |=> cnt[STAGES-1] != $past(cnt[STAGES-1]));

  p_stage_hold_r4: assert property (@(posedge clk_in) disable iff (!rst_n)
    !tick[STAGES-1] |=> $stable(cnt[STAGES-1]));

  // R5: slow divide-by-three output moves only on a tap transition
  p_slow_hold_r5: assert property (@(posedge clk_in) disable iff (!rst_n)
    !tick_sel |=> $stable(slow));

  // R6: raw-path pulse lasts a single input period
  p_pulse_single_r6: assert property (@(posedge clk_in) disable iff (!rst_n)
    pulse |=> !pulse);

endmodule

bind tapdiv tapdiv_chk #(.STAGES(STAGES), .SEL_W(SEL_W)) u_chk (
  .clk_in   (clk_in),
  .rst_n    (rst_n),
  .sel      (sel),
  .div3_en  (div3_en),
  .clk_out  (clk_out),
  .cnt      (chain_cnt),
  .tick     (chain_tick),
  .tick_sel (tick_sel),
  .pulse    (d3_pulse),
  .slow     (d3_slow)
);

// File: tb/tapdiv_test.sv
module tapdiv_test;

  localparam int CLK_PERIOD = 10;
  localparam int EDGES      = 800;
  localparam int WATCHDOG   = 40000 * CLK_PERIOD;

  logic       clk_in = 1'b0;
  logic       rst_n  = 1'b0;
  logic [2:0] sel    = 3'd0;
  logic       div3_en = 1'b0;
  logic       clk_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  tapdiv uut (
    .clk_in  (clk_in),
    .rst_n   (rst_n),
    .sel     (sel),
    .div3_en (div3_en),
    .clk_out (clk_out)
  );

  always #(CLK_PERIOD / 2) clk_in = ~clk_in;

  task automatic check(input string req, input logic act, input logic exp,
                       input int n, input bit hi);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s sel=%0d div3=%0d edge=%0d phase=%s actual=%b expected=%b",
               req, sel, div3_en, n, hi ? "high" : "low", act, exp);
    end
  endtask

  // Expected output after n rising edges, in the high or low phase of clk_in
  function automatic logic model(input int code, input bit en, input int n, input bit hi);
    int e;
    if (!en) begin
      if (code == 0) return hi;
      return ((n % 128) >> (code - 1)) & 1;
    end
    if (code == 0) begin
      if (hi) return (n > 0 && n % 3 == 0) || (n - 1 > 0 && (n - 1) % 3 == 0);
      return n > 0 && n % 3 == 0;
    end
    e = n >> (code - 1);
    return (e / 3) % 2;
  endfunction

  initial begin
    for (int en = 0; en < 2; en++) begin
      for (int code = 0; code < 8; code++) begin
        rst_n   = 1'b0;
        sel     = code[2:0];
        div3_en = en[0];
        repeat (3) @(posedge clk_in);
        #2;
        // R1: output held low during reset
        if (code != 0 || en != 0) check("R1", clk_out, 1'b0, 0, 1);
        @(negedge clk_in);
        #2;
        if (code != 0 || en != 0) check("R1", clk_out, 1'b0, 0, 0);
        rst_n = 1'b1;
        for (int n = 1; n <= EDGES; n++) begin
          @(posedge clk_in);
          #2;
          if (!en && code == 0)  check("R2", clk_out, model(code, en, n, 1), n, 1);
          else if (!en)          check("R3/R4", clk_out, model(code, en, n, 1), n, 1);
          else if (code == 0)    check("R6", clk_out, model(code, en, n, 1), n, 1);
          else                   check("R5", clk_out, model(code, en, n, 1), n, 1);
          @(negedge clk_in);
          #2;
          if (!en && code == 0)  check("R2", clk_out, model(code, en, n, 0), n, 0);
          else if (!en)          check("R3/R4", clk_out, model(code, en, n, 0), n, 0);
          else if (code == 0)    check("R6", clk_out, model(code, en, n, 0), n, 0);
          else                   check("R5", clk_out, model(code, en, n, 0), n, 0);
        end
      end
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(WATCHDOG);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule